// File: doc/BRIEF.md
# Single-Cycle 32-Bit Register-Machine Core

This block is a small processor core that completes one instruction in every clock cycle. It keeps 64 general registers of 32 bits. The highest-numbered register, index 63, holds the address of the instruction being executed. There is no branch or jump opcode: writing index 63 with any instruction that has a destination moves execution to the written value. When an instruction does not write index 63, execution steps to the next word.

Four instruction kinds are decoded. The first is a register-register operate that shifts its first source by a byte multiple, combines it with its second source in an eight-function ALU, and shifts the ALU result by a signed amount. The other three are add-immediate, load and store. Loads add their sign-extended displacement to the base register. Stores subtract theirs.

The core reads instructions through a word-addressed fetch port and data through a word-addressed data port. Both memories return data in the same cycle. Writes to data memory take effect at the clock edge. A small two-state controller holds the core idle for one cycle after reset, then runs continuously:

- Reset forces `ST_BOOT`.
- `ST_BOOT` goes to `ST_RUN` at the next edge.
- `ST_RUN` stays in `ST_RUN`.

Top module: `regcore32`

## Requirements
- R1: An active-low asynchronous reset clears all 64 registers, including index 63, and enters `ST_BOOT`. In `ST_BOOT` the fetch address is 0, no register or memory is written, and the state moves to `ST_RUN` at the next edge. The instruction at word 0 therefore executes in the first `ST_RUN` cycle.
- R2: Instruction bit fields are as follows:
  - bits 31:30 are the kind: 0 operate, 1 add-immediate, 2 load, 3 store;
  - bits 29:24 are the destination (or store source) index D;
  - bits 23:18 are the base/first source index A;
  - bits 17:15 are the ALU code;
  - bits 14:12 are the pre-shift code;
  - bits 11:6 are the signed post-shift amount;
  - bits 5:0 are the second source index B;
  - for the other three kinds, bits 17:0 are a two's-complement displacement.
- R3: Operate writes D with the ALU result, where A' is A after its pre-shift. ALU codes are: 0 A'+B, 1 A'-B, 2 A'&B, 3 A'|B, 4 A'^B, 5 B, 6 A'&~B, 7 A'.
- R4: Pre-shift codes applied to A are: 0 none, 1/2/3 left by 8/16/24, 4/5/6 logical right by 8/16/24, 7 none.
- R5: The post-shift amount s (-32..31) shifts the ALU result left by s when s >= 0. When s < 0 it shifts arithmetically right by -s, so -32 fills every bit with the sign.
- R6: Add-immediate writes D with A plus the sign-extended 18-bit displacement.
- R7: Load writes D with the data word at address A plus the sign-extended displacement.
- R8: Store drives the data write enable for exactly that cycle. The write address is A minus the sign-extended displacement, and the write data is D. Store changes no register and lets index 63 step by 1.
- R9: Index 63 steps by 1 after each `ST_RUN` instruction unless that instruction writes index 63. If it does, the written value (operate, add-immediate or loaded data) is the next fetch address.
- R10: Source reads return values from before the current instruction's write, and a read of index 63 yields the current instruction's own address. A written value is visible to the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Word address of the instruction to execute (value of index 63) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Word address for load or store |
| dmem_we | output | 1 | Store strobe; memory writes at the next rising edge |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |

## Verification
The assertions take for granted two things about the inputs:

- The fetch port returns a defined instruction word for every address the core issues.
- The data port returns a defined word in the same cycle as a load address.

Under those conditions the checks on next-address stepping, jump targets and register write-back are meaningful. The stimulus keeps within these assumptions in three ways:

- Every word of both memory models is filled before reset is released, and empty instruction slots hold a harmless operate that writes register 0 with 0+0.
- Every address the programs generate falls inside the modelled ranges.
- Each program finishes in a self-jump, so the core never runs off into undefined contents.

// File: rtl/rc_pkg.sv
package rc_pkg;

    parameter int XLEN    = 32;
    parameter int RIDX_W  = 6;
    parameter int KIND_W  = 2;
    parameter int CODE_W  = 3;
    parameter int SH_W    = 6;
    parameter int DISP_W  = 18;
    parameter int BYTE_W  = 8;

    localparam int NREG    = 1 << RIDX_W;
    localparam int POS_B   = 0;
    localparam int POS_SH  = POS_B + RIDX_W;
    localparam int POS_PRE = POS_SH + SH_W;
    localparam int POS_ALU = POS_PRE + CODE_W;
    localparam int POS_A   = POS_ALU + CODE_W;
    localparam int POS_D   = POS_A + RIDX_W;
    localparam int POS_K   = POS_D + RIDX_W;

    typedef enum logic [KIND_W-1:0] {
        K_OPER  = 2'd0,
        K_ADDI  = 2'd1,
        K_LOAD  = 2'd2,
        K_STORE = 2'd3
    } kind_e;

    typedef enum logic [CODE_W-1:0] {
        F_ADD  = 3'd0,
        F_SUB  = 3'd1,
        F_AND  = 3'd2,
        F_OR   = 3'd3,
        F_XOR  = 3'd4,
        F_PASB = 3'd5,
        F_ANDN = 3'd6,
        F_PASA = 3'd7
    } func_e;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } core_state_e;

    typedef struct packed {
        kind_e              kind;
        logic [RIDX_W-1:0]  d_idx;
        logic [RIDX_W-1:0]  a_idx;
        logic [RIDX_W-1:0]  b_idx;
        func_e              func;
        logic [CODE_W-1:0]  pre;
        logic [SH_W-1:0]    post;
        logic [XLEN-1:0]    disp;
    } dec_t;

endpackage

// File: rtl/rc_decode.sv
module rc_decode
    import rc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);

    always_comb begin
        dec.kind  = kind_e'(instr[POS_K +: KIND_W]);
        dec.d_idx = instr[POS_D +: RIDX_W];
        dec.a_idx = instr[POS_A +: RIDX_W];
        dec.b_idx = instr[POS_B +: RIDX_W];
        dec.func  = func_e'(instr[POS_ALU +: CODE_W]);
        dec.pre   = instr[POS_PRE +: CODE_W];
        dec.post  = instr[POS_SH +: SH_W];
        dec.disp  = {{(XLEN-DISP_W){instr[DISP_W-1]}}, instr[DISP_W-1:0]};
    end

endmodule

// File: rtl/rc_operate.sv
module rc_operate
    import rc_pkg::*;
(
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  func_e             func,
    input  logic [CODE_W-1:0] pre,
    input  logic [SH_W-1:0]   post,
    output logic [XLEN-1:0]   result
);

    logic [XLEN-1:0] a_pre;
    logic [XLEN-1:0] f_out;
    logic [SH_W:0]   post_ext;
    logic [SH_W:0]   post_mag;

    always_comb begin
        unique case (pre)
            3'd1:    a_pre = src_a << BYTE_W;
            3'd2:    a_pre = src_a << (2 * BYTE_W);
            3'd3:    a_pre = src_a << (3 * BYTE_W);
            3'd4:    a_pre = src_a >> BYTE_W;
            3'd5:    a_pre = src_a >> (2 * BYTE_W);
            3'd6:    a_pre = src_a >> (3 * BYTE_W);
            default: a_pre = src_a;
        endcase
    end

    always_comb begin
        unique case (func)
            F_ADD:   f_out = a_pre + src_b;
            F_SUB:   f_out = a_pre - src_b;
            F_AND:   f_out = a_pre & src_b;
            F_OR:    f_out = a_pre | src_b;
            F_XOR:   f_out = a_pre ^ src_b;
            F_PASB:  f_out = src_b;
            F_ANDN:  f_out = a_pre & ~src_b;
            default: f_out = a_pre;
        endcase
    end

    always_comb begin
        post_ext = {post[SH_W-1], post};
        post_mag = post[SH_W-1] ? (~post_ext + 1'b1) : post_ext;
        if (post[SH_W-1]) begin
            result = $unsigned($signed(f_out) >>> post_mag);
        end else begin
            result = f_out << post_mag;
        end
    end

endmodule

// File: rtl/rc_regfile.sv
module rc_regfile
    import rc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] a_idx,
    input  logic [RIDX_W-1:0] b_idx,
    input  logic [RIDX_W-1:0] c_idx,
    output logic [XLEN-1:0]   a_val,
    output logic [XLEN-1:0]   b_val,
    output logic [XLEN-1:0]   c_val,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_val,
    input  logic              step_en,
    output logic [XLEN-1:0]   pc_val
);

    localparam logic [RIDX_W-1:0] PC_SEL = RIDX_W'(NREG - 1);

    logic [NREG-1:0][XLEN-1:0] regs;

    assign a_val  = regs[a_idx];
    assign b_val  = regs[b_idx];
    assign c_val  = regs[c_idx];
    assign pc_val = regs[PC_SEL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs <= '0;
        end else begin
            if (step_en && !(wr_en && wr_idx == PC_SEL)) begin
                regs[PC_SEL] <= regs[PC_SEL] + XLEN'(1);
            end
            if (wr_en) begin
                regs[wr_idx] <= wr_val;
            end
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(wr_idx)] == $past(wr_val))); // R10

    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !step_en) |=> $stable(pc_val)); // R1

endmodule

// File: rtl/regcore32.sv
module regcore32
    import rc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [31:0]     imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [31:0]     dmem_addr,
    output logic            dmem_we,
    output logic [31:0]     dmem_wdata,
    input  logic [31:0]     dmem_rdata
);

    localparam logic [RIDX_W-1:0] PC_SEL = RIDX_W'(NREG - 1);

    core_state_e     state;
    core_state_e     state_nxt;
    dec_t            dec;
    logic [XLEN-1:0] a_val;
    logic [XLEN-1:0] b_val;
    logic [XLEN-1:0] c_val;
    logic [XLEN-1:0] pc_val;
    logic [XLEN-1:0] op_res;
    logic [XLEN-1:0] addr_up;
    logic [XLEN-1:0] addr_dn;
    logic [XLEN-1:0] wb_val;
    logic            wr_en;
    logic            step_en;
    logic            st_we;
    logic            pc_wr;

    rc_decode u_dec (
        .instr (imem_rdata),
        .dec   (dec)
    );

    rc_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_idx   (dec.a_idx),
        .b_idx   (dec.b_idx),
        .c_idx   (dec.d_idx),
        .a_val   (a_val),
        .b_val   (b_val),
        .c_val   (c_val),
        .wr_en   (wr_en),
        .wr_idx  (dec.d_idx),
        .wr_val  (wb_val),
        .step_en (step_en),
        .pc_val  (pc_val)
    );

    rc_operate u_op (
        .src_a  (a_val),
        .src_b  (b_val),
        .func   (dec.func),
        .pre    (dec.pre),
        .post   (dec.post),
        .result (op_res)
    );

    assign addr_up = a_val + dec.disp;
    assign addr_dn = a_val - dec.disp;

    always_comb begin
        unique case (dec.kind)
            K_OPER:  wb_val = op_res;
            K_ADDI:  wb_val = addr_up;
            K_LOAD:  wb_val = dmem_rdata;
            default: wb_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BOOT;
        end else begin
            state <= state_nxt;
        end
    end

    // next state and per-state outputs
    always_comb begin
        state_nxt = state;
        wr_en     = 1'b0;
        step_en   = 1'b0;
        st_we     = 1'b0;
        unique case (state)
            ST_BOOT: begin
                state_nxt = ST_RUN;
            end
            ST_RUN: begin
                step_en = 1'b1;
                wr_en   = (dec.kind != K_STORE);
                st_we   = (dec.kind == K_STORE);
            end
            default: state_nxt = ST_BOOT;
        endcase
    end

    assign pc_wr      = wr_en && (dec.d_idx == PC_SEL);
    assign imem_addr  = pc_val;
    assign dmem_we    = st_we;
    assign dmem_addr  = (dec.kind == K_STORE) ? addr_dn : addr_up;
    assign dmem_wdata = c_val;

    AST_BOOT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BOOT) |-> (imem_addr == '0 && !dmem_we)); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !pc_wr) |=> (imem_addr == $past(imem_addr) + 32'd1)); // R9

    AST_PC_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && pc_wr) |=> (imem_addr == $past(wb_val))); // R9

    AST_STORE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> (imem_addr == $past(imem_addr) + 32'd1)); // R8

endmodule

// File: tb/sim_regcore32.sv
`timescale 1ns/1ps
module sim_regcore32;

    logic        clk;
    logic        rst_n;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata;
    logic [31:0] dmem_addr;
    logic        dmem_we;
    logic [31:0] dmem_wdata;
    logic [31:0] dmem_rdata;

    logic [31:0] imem [512];
    logic [31:0] dmem [512];

    int          checks   = 0;
    int          failures = 0;
    bit          done     = 0;

    logic [31:0] q_addr [$];
    logic [31:0] q_data [$];
    string       q_tag  [$];

    int pc;
    int slot;

    initial clk = 1'b0;
    always #4 clk = ~clk;

    regcore32 u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[8:0]];
    assign dmem_rdata = dmem[dmem_addr[8:0]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[8:0]] <= dmem_wdata;
    end

    function automatic logic [31:0] f_oper(int fn, int pre, int d, int a, int sh, int b);
        return {2'b00, d[5:0], a[5:0], fn[2:0], pre[2:0], sh[5:0], b[5:0]};
    endfunction

    function automatic logic [31:0] f_imm(int kind, int d, int a, int disp);
        return {kind[1:0], d[5:0], a[5:0], disp[17:0]};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] w);
        imem[pc] = w;
        pc++;
    endtask

    task automatic expect_store(input logic [31:0] a, input logic [31:0] d, input string tag);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    // store register rs into the next result slot (base r10 = 100, negative displacement)
    task automatic store_slot(input int rs, input logic [31:0] exp, input string tag);
        put(f_imm(3, rs, 10, -slot));
        expect_store(32'(100 + slot), exp, tag);
        slot++;
    endtask

    task automatic op_case(input int fn, input int pre, input int a, input int b,
                           input int sh, input logic [31:0] exp, input string tag);
        put(f_oper(fn, pre, 20, a, sh, b));
        store_slot(20, exp, tag);
    endtask

    task automatic read_pc_case(input string tag);
        logic [31:0] here;
        here = 32'(pc);
        put(f_oper(7, 0, 20, 63, 0, 0));
        store_slot(20, here, tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && dmem_we) begin
            if (q_addr.size() == 0) begin
                check(1'b0, "R8 unexpected store", dmem_addr, 32'h0);
            end else begin
                logic [31:0] ea;
                logic [31:0] ed;
                string       et;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                et = q_tag.pop_front();
                check(dmem_addr == ea, {et, " address"}, dmem_addr, ea);
                check(dmem_wdata == ed, {et, " data"}, dmem_wdata, ed);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int loop_at;
        for (int i = 0; i < 512; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
        dmem[50] = 32'hCAFEF00D;
        dmem[60] = 32'd300;
        pc   = 0;
        slot = 0;

        // constants: r1, r2, r4, r10 (R6)
        put(f_imm(1, 1, 0, 32'h12345));
        put(f_imm(1, 2, 0, -3));
        put(f_imm(1, 4, 0, 32'h0F0F0));
        put(f_imm(1, 10, 0, 100));
        store_slot(1, 32'h00012345, "R6 positive add-immediate");
        store_slot(2, 32'hFFFFFFFD, "R6 sign-extended negative");

        // ALU functions (R3)
        op_case(0, 0, 1, 4, 0, 32'h00021435, "R3 add");
        op_case(1, 0, 1, 4, 0, 32'h00003255, "R3 sub");
        op_case(2, 0, 1, 4, 0, 32'h00002040, "R3 and");
        op_case(3, 0, 1, 4, 0, 32'h0001F3F5, "R3 or");
        op_case(4, 0, 1, 4, 0, 32'h0001D3B5, "R3 xor");
        op_case(5, 0, 1, 4, 0, 32'h0000F0F0, "R3 pass B");
        op_case(6, 0, 1, 4, 0, 32'h00010305, "R3 and-not");
        op_case(7, 0, 1, 4, 0, 32'h00012345, "R3 pass A");
        op_case(0, 0, 1, 2, 0, 32'h00012342, "R3 add negative");
        op_case(1, 0, 4, 1, 0, 32'hFFFFCDAB, "R3 sub operand order");

        // pre-shift of A (R4)
        op_case(7, 1, 2, 0, 0, 32'hFFFFFD00, "R4 left 8");
        op_case(7, 2, 2, 0, 0, 32'hFFFD0000, "R4 left 16");
        op_case(7, 3, 2, 0, 0, 32'hFD000000, "R4 left 24");
        op_case(7, 4, 2, 0, 0, 32'h00FFFFFF, "R4 right 8");
        op_case(7, 5, 2, 0, 0, 32'h0000FFFF, "R4 right 16");
        op_case(7, 6, 2, 0, 0, 32'h000000FF, "R4 right 24");
        op_case(7, 7, 2, 0, 0, 32'hFFFFFFFD, "R4 code 7 none");

        // post-shift (R5)
        op_case(7, 0, 2, 0, 4,   32'hFFFFFFD0, "R5 left 4");
        op_case(7, 0, 2, 0, -1,  32'hFFFFFFFE, "R5 arith right 1");
        op_case(7, 0, 2, 0, -32, 32'hFFFFFFFF, "R5 right 32 negative");
        op_case(7, 0, 1, 0, -4,  32'h00001234, "R5 right 4 positive");
        op_case(7, 0, 1, 0, 31,  32'h80000000, "R5 left 31");
        op_case(7, 0, 1, 0, -32, 32'h00000000, "R5 right 32 positive");

        // field layout and stage order (R2)
        op_case(0, 1, 1, 4, -4, 32'h0012435F, "R2 pre-shift then ALU then post-shift");

        // loads (R7)
        put(f_imm(2, 21, 10, 1));
        store_slot(21, 32'hFFFFFFFD, "R7 load positive displacement");
        put(f_imm(2, 22, 10, -50));
        store_slot(22, 32'hCAFEF00D, "R7 load negative displacement");

        // store subtracts a positive displacement (R8)
        put(f_imm(1, 11, 0, 300));
        put(f_imm(3, 1, 11, 5));
        expect_store(32'd295, 32'h00012345, "R8 store subtracts displacement");

        // same-cycle read returns old value (R10)
        put(f_imm(1, 23, 0, 7));
        put(f_oper(0, 0, 23, 23, 0, 23));
        store_slot(23, 32'd14, "R10 doubled through own write");
        read_pc_case("R10 read of index 63");

        // jump via add-immediate (R9); the decoy store must not run
        put(f_imm(1, 63, 0, 200));
        put(f_imm(3, 1, 10, -400));
        pc = 200;
        read_pc_case("R9 add-immediate jump target");

        // jump via operate
        put(f_imm(1, 30, 0, 260));
        put(f_oper(7, 0, 63, 30, 0, 0));
        put(f_imm(3, 1, 10, -400));
        pc = 260;
        read_pc_case("R9 operate jump target");

        // jump via load
        put(f_imm(2, 63, 0, 60));
        put(f_imm(3, 1, 10, -400));
        pc = 300;
        read_pc_case("R9 load jump target");

        loop_at = pc;
        put(f_imm(1, 63, 63, 0));

        // reset and boot (R1)
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(imem_addr == 32'h0 && !dmem_we, "R1 in reset", imem_addr, 32'h0);
        rst_n = 1'b1;
        #1;
        check(imem_addr == 32'h0 && !dmem_we, "R1 boot cycle", imem_addr, 32'h0);
        @(negedge clk);
        check(imem_addr == 32'h0, "R1 first run fetch at 0", imem_addr, 32'h0);
        @(negedge clk);
        check(imem_addr == 32'h1, "R9 step by one", imem_addr, 32'h1);

        repeat (400) @(negedge clk);
        check(q_addr.size() == 0, "R8 all expected stores seen",
              32'(q_addr.size()), 32'h0);
        check(imem_addr == 32'(loop_at), "R9 self-jump holds", imem_addr, 32'(loop_at));
        check(dmem[500] == 32'h0, "R9 skipped decoy store", dmem[500], 32'h0);
        check(dmem[100] == 32'h00012345, "R8 memory holds stored word", dmem[100], 32'h00012345);
        finish_run();
    end

endmodule